// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block supervises a memory that pairs fast static storage with a nonvolatile shadow. It watches an asynchronous SRAM-style bus, sampled on the system clock, and decides when the whole array is copied into the shadow (STORE) or copied back (RECALL). It offers three ways to ask for this. Software sends a chain of six reads. An external agent pulls a shared open-drain busy/request line low. A power monitor reports loss and return of main supply. STORE and RECALL are modelled as timed internal phases whose lengths are parameters. While a phase runs, the block drives phase strobes for the array.

The block gates the array's read and write strobes. It refuses writes while a nonvolatile cycle runs or power is absent. After any nonvolatile cycle, and after reset, it demands a fresh write strobe before accepting a write. It keeps a "modified since last nonvolatile cycle" flag so that hardware and power-fail stores are skipped when nothing changed. The open-drain line is split into a sampled input and a pull-low enable. The system wires them together, AND-ed with any external pull.

Top module: `nv_cycle_ctrl`

## Requirements
- R1: Six reads whose low CMP_W address bits are 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and then 0x0FC0 start a STORE. `busy_pull` is then high for exactly STORE_CYC cycles. The STORE runs whether or not any write occurred.
- R2: The same five leading reads followed by 0x0C63 start a RECALL. `recall_clear` is high for CLR_CYC cycles. It is followed directly by `recall_load`, which is high for XFER_CYC cycles.
- R3: A cycle with chip-enable and write-enable both low aborts a partly entered chain, and no operation starts. A read of an address that is not the next expected one also aborts it, and so does a second read of the same address. The matcher then expects the first address again.
- R4: Once the request line is sampled low while idle, a window of DLY_CYC cycles follows. Reads stay enabled during the window. A write that is active when the low line is first seen keeps `wr_en` until it ends. Writes begun later are refused.
- R5: An accepted write marks the array modified. A completed STORE or RECALL clears that mark. A hardware-request window or power loss starts a STORE only when the array is marked modified.
- R6: `busy_pull` is high only during a STORE. After the STORE, and after a hardware window that ends without one, `rd_en` and `wr_en` stay low until the request line is sampled high.
- R7: While `pwr_ok` is low, `rd_en` and `wr_en` are low. Power loss while idle starts a STORE if the array is modified. It also latches a RECALL, which runs when `pwr_ok` is high again. Reset behaves as a power-up and triggers a RECALL.
- R8: During STORE and RECALL, `rd_en` and `wr_en` are low.
- R9: After reset, STORE or RECALL, `wr_en` stays low while chip-enable and write-enable are both held low. It returns only after one of them has been seen high.
- R10: Address bits at and above CMP_W take no part in chain matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset, treated as power-up |
| bus_ce_n | input | 1 | Bus chip-enable, active low |
| bus_we_n | input | 1 | Bus write-enable, active low |
| bus_addr | input | ADDR_W | Bus address |
| hsb_in_n | input | 1 | Sampled level of the shared busy/request line |
| pwr_ok | input | 1 | High while main supply is above the switch threshold |
| busy_pull | output | 1 | Pull the shared line low (STORE in progress) |
| recall_clear | output | 1 | RECALL phase 1: clear the array |
| recall_load | output | 1 | RECALL phase 2: copy shadow into the array |
| rd_en | output | 1 | Array reads permitted |
| wr_en | output | 1 | Array writes permitted |

## Verification
The assertions assume that `busy_pull` and any external pull are wired together as an open-drain net that feeds `hsb_in_n`. They also assume that bus inputs change only once per clock and are stable around the sampling edge. The bench models the line as exactly that wired-AND and drives all inputs just after the rising edge. It keeps each chip-enable access low for one whole clock, with a high clock between accesses, so every read registers as a distinct falling edge. Power and request changes are held long enough for a whole window or phase to play out.

// File: rtl/nvc_pkg.sv
// Shared types and constants for the nonvolatile cycle sequencer.
// Assumes chain keys fit in 16 bits; callers slice to their compare width.
package nvc_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_HWIN  = 3'd1,
        S_STORE = 3'd2,
        S_RCLR  = 3'd3,
        S_RLOAD = 3'd4,
        S_WREL  = 3'd5
    } nvc_state_t;

    localparam logic [15:0] KEY_STORE  = 16'h0FC0;
    localparam logic [15:0] KEY_RECALL = 16'h0C63;
    localparam int          LEAD_LEN   = 5;

    // Leading chain address for a given step.
    function automatic logic [15:0] lead_key(input logic [2:0] idx);
        case (idx)
            3'd0:    lead_key = 16'h0E38;
            3'd1:    lead_key = 16'h31C7;
            3'd2:    lead_key = 16'h03E0;
            3'd3:    lead_key = 16'h3C1F;
            3'd4:    lead_key = 16'h303F;
            default: lead_key = 16'hFFFF;
        endcase
    endfunction

endpackage

// File: rtl/nvc_seq_match.sv
// Software chain matcher: tracks progress through the five leading reads
// and flags the sixth read as a store or recall request.
// Assumes rd_stb marks one cycle per read access (chip-enable falling edge).
module nvc_seq_match
    import nvc_pkg::*;
#(
    parameter int CMP_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rd_stb,
    input  logic             wr_act,
    input  logic [CMP_W-1:0] addr_lo,
    output logic             fire_store,
    output logic             fire_recall
);
    logic [2:0] step;
    logic       last_step;
    logic       hit_lead;

    // Decode the current read against the expected key.
    always_comb begin
        last_step   = (step == 3'(LEAD_LEN));
        hit_lead    = (addr_lo == lead_key(step)[CMP_W-1:0]);
        fire_store  = en & rd_stb & ~wr_act & last_step & (addr_lo == KEY_STORE[CMP_W-1:0]);
        fire_recall = en & rd_stb & ~wr_act & last_step & (addr_lo == KEY_RECALL[CMP_W-1:0]);
    end

    // Advance on a matching read, fall back to the start on anything else.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || wr_act) begin
            step <= 3'd0;
        end else if (rd_stb) begin
            if (last_step || !hit_lead) step <= 3'd0;
            else                        step <= step + 3'd1;
        end
    end

endmodule

// File: rtl/nvc_down_cnt.sv
// Loadable down counter used to time windows and phases.
// A phase lasting L cycles is loaded with L-1; zero marks its last cycle.
module nvc_down_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    // Load on request, otherwise count down and rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/nvc_wr_guard.sv
// Write re-arm and modified tracking.
// armed drops at each completed nonvolatile cycle and at reset, and returns
// once chip-enable or write-enable is seen high; modified follows writes.
module nvc_wr_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic wr_take,
    input  logic op_done,
    output logic armed,
    output logic modified
);
    // Require a fresh write strobe after reset or a nonvolatile cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || op_done) armed <= 1'b0;
        else if (ce_n || we_n) armed <= 1'b1;
    end

    // Record that the array differs from its shadow.
    always_ff @(posedge clk) begin
        if (!rst_n || op_done) modified <= 1'b0;
        else if (wr_take)      modified <= 1'b1;
    end

endmodule

// File: rtl/nv_cycle_ctrl.sv
// Nonvolatile store/recall sequencer. Samples an asynchronous SRAM-style
// bus on clk, arbitrates software, hardware-line and power requests, times
// the STORE and RECALL phases and gates array access.
// Assumes hsb_in_n is the wired-AND of busy_pull and any external pull.
module nv_cycle_ctrl
    import nvc_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int CMP_W     = 14,
    parameter int STORE_CYC = 4000,
    parameter int CLR_CYC   = 64,
    parameter int XFER_CYC  = 1000,
    parameter int DLY_CYC   = 250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ce_n,
    input  logic              bus_we_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              hsb_in_n,
    input  logic              pwr_ok,
    output logic              busy_pull,
    output logic              recall_clear,
    output logic              recall_load,
    output logic              rd_en,
    output logic              wr_en
);
    localparam int MAX_A = (STORE_CYC > XFER_CYC) ? STORE_CYC : XFER_CYC;
    localparam int MAX_B = (CLR_CYC > DLY_CYC) ? CLR_CYC : DLY_CYC;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(MAX_C + 1);
    localparam logic [CNT_W-1:0] LD_STORE = CNT_W'(STORE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_CLR   = CNT_W'(CLR_CYC - 1);
    localparam logic [CNT_W-1:0] LD_XFER  = CNT_W'(XFER_CYC - 1);
    localparam logic [CNT_W-1:0] LD_DLY   = CNT_W'(DLY_CYC - 1);

    nvc_state_t       st, st_d;
    logic             ce_q, hsb_q, pend, pend_d, wip, wip_d;
    logic             cnt_load, cnt_zero;
    logic [CNT_W-1:0] cnt_val;
    logic             armed, modified, op_done;
    logic             wr_act, wr_take, rd_stb, seq_en, fire_store, fire_recall;

    // Bus event decode and access gating.
    always_comb begin
        wr_act  = ~bus_ce_n & ~bus_we_n;
        rd_stb  = ce_q & ~bus_ce_n & bus_we_n;
        rd_en   = pwr_ok & ((st == S_IDLE) | (st == S_HWIN));
        wr_en   = pwr_ok & armed & ((st == S_IDLE) | ((st == S_HWIN) & wip));
        wr_take = wr_act & wr_en;
        seq_en  = (st == S_IDLE) & pwr_ok & hsb_q & ~pend;
        op_done = cnt_zero & ((st == S_STORE) | (st == S_RLOAD));
    end

    assign busy_pull    = (st == S_STORE);
    assign recall_clear = (st == S_RCLR);
    assign recall_load  = (st == S_RLOAD);

    // Request arbitration and phase sequencing.
    always_comb begin
        st_d     = st;
        cnt_load = 1'b0;
        cnt_val  = '0;
        pend_d   = pend | ~pwr_ok;
        wip_d    = 1'b0;
        case (st)
            S_IDLE: begin
                if (!pwr_ok) begin
                    if (modified) begin
                        st_d = S_STORE; cnt_load = 1'b1; cnt_val = LD_STORE;
                    end
                end else if (pend) begin
                    st_d = S_RCLR; cnt_load = 1'b1; cnt_val = LD_CLR; pend_d = 1'b0;
                end else if (!hsb_q) begin
                    st_d = S_HWIN; cnt_load = 1'b1; cnt_val = LD_DLY; wip_d = wr_take;
                end else if (fire_store) begin
                    st_d = S_STORE; cnt_load = 1'b1; cnt_val = LD_STORE;
                end else if (fire_recall) begin
                    st_d = S_RCLR; cnt_load = 1'b1; cnt_val = LD_CLR;
                end
            end
            S_HWIN: begin
                wip_d = wip & wr_act;
                if (cnt_zero) begin
                    if (modified) begin
                        st_d = S_STORE; cnt_load = 1'b1; cnt_val = LD_STORE;
                    end else begin
                        st_d = S_WREL;
                    end
                end
            end
            S_STORE: if (cnt_zero) st_d = S_WREL;
            S_RCLR: begin
                if (cnt_zero) begin
                    st_d = S_RLOAD; cnt_load = 1'b1; cnt_val = LD_XFER;
                end
            end
            S_RLOAD: if (cnt_zero) st_d = S_IDLE;
            S_WREL:  if (hsb_q) st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    // State, sampled bus levels and pending-recall latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= S_IDLE;
            ce_q  <= 1'b1;
            hsb_q <= 1'b1;
            pend  <= 1'b1;
            wip   <= 1'b0;
        end else begin
            st    <= st_d;
            ce_q  <= bus_ce_n;
            hsb_q <= hsb_in_n;
            pend  <= pend_d;
            wip   <= wip_d;
        end
    end

    nvc_seq_match #(.CMP_W(CMP_W)) u_match (
        .clk(clk), .rst_n(rst_n), .en(seq_en), .rd_stb(rd_stb), .wr_act(wr_act),
        .addr_lo(bus_addr[CMP_W-1:0]), .fire_store(fire_store), .fire_recall(fire_recall)
    );

    nvc_down_cnt #(.W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
    );

    nvc_wr_guard u_guard (
        .clk(clk), .rst_n(rst_n), .ce_n(bus_ce_n), .we_n(bus_we_n),
        .wr_take(wr_take), .op_done(op_done), .armed(armed), .modified(modified)
    );

endmodule

// File: rtl/nv_cycle_ctrl_chk.sv
// Port-level property checker for nv_cycle_ctrl, attached with bind.
// Assumes the reset is synchronous and active low.
module nv_cycle_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_ok,
    input logic bus_ce_n,
    input logic bus_we_n,
    input logic busy_pull,
    input logic recall_clear,
    input logic recall_load,
    input logic rd_en,
    input logic wr_en
);
    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy_pull, recall_clear, recall_load, rd_en})); // R8

    AST_WR_IMPLIES_RD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> rd_en); // R8

    AST_NOPWR_NOACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |-> (!rd_en && !wr_en)); // R7

    AST_CLEAR_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(recall_clear) |-> recall_load); // R2

    AST_LOAD_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(recall_load) |-> $past(recall_clear)); // R2

    AST_STORE_END_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_pull) |-> !rd_en); // R6

    AST_WRITE_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (($fell(recall_load) || $fell(busy_pull)) && !bus_ce_n && !bus_we_n) |-> !wr_en); // R9

endmodule

bind nv_cycle_ctrl nv_cycle_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n),
    .busy_pull(busy_pull), .recall_clear(recall_clear), .recall_load(recall_load),
    .rd_en(rd_en), .wr_en(wr_en)
);

// File: tb/nv_cycle_ctrl_tb_top.sv
// Bench: behavioural reference compared every clock, plus directed checks.
module nv_cycle_ctrl_tb_top;
    localparam int AW = 16, CW = 14, ST = 20, CL = 4, XF = 10, DL = 6;
    localparam int MASK = (1 << CW) - 1;
    localparam int M_IDLE = 0, M_HWIN = 1, M_ST = 2, M_CLR = 3, M_LD = 4, M_REL = 5;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0, ce_n = 1'b1, we_n = 1'b1, pwr_ok = 1'b1, ext_pull = 1'b0;
    logic [AW-1:0] addr = '0;
    wire busy_pull, recall_clear, recall_load, rd_en, wr_en;
    wire hsb_line = ~(ext_pull | busy_pull);

    nv_cycle_ctrl #(.ADDR_W(AW), .CMP_W(CW), .STORE_CYC(ST), .CLR_CYC(CL),
                    .XFER_CYC(XF), .DLY_CYC(DL)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_we_n(we_n), .bus_addr(addr),
        .hsb_in_n(hsb_line), .pwr_ok(pwr_ok), .busy_pull(busy_pull),
        .recall_clear(recall_clear), .recall_load(recall_load), .rd_en(rd_en), .wr_en(wr_en)
    );

    int checks = 0, errors = 0, cyc_checks = 0, cyc_errors = 0, wd_err = 0;
    int n_st = 0, n_cl = 0, n_ld = 0;

    // ---------------- behavioural reference ----------------
    int ms = M_IDLE, rem = 0, mstep = 0;
    bit mdirty = 0, marm = 0, mpend = 1, mwip = 0, mhsbq = 1, mceq = 1, started = 0;
    int unsigned lead [0:4] = '{32'h0E38, 32'h31C7, 32'h03E0, 32'h3C1F, 32'h303F};

    always @(posedge clk) begin : ref_model
        bit mwr, wact, wnow, rstb, sen, fs, fr, done, npend, nwip;
        int ns, nrem;
        started = 1;
        if (!rst_n) begin
            ms = M_IDLE; rem = 0; mstep = 0; mdirty = 0; marm = 0;
            mpend = 1; mwip = 0; mhsbq = 1; mceq = 1;
        end else begin
            wact = !ce_n && !we_n;
            mwr  = pwr_ok && marm && (ms == M_IDLE || (ms == M_HWIN && mwip));
            wnow = wact && mwr;
            rstb = mceq && !ce_n && we_n;
            sen  = (ms == M_IDLE) && pwr_ok && mhsbq && !mpend;
            fs = 0; fr = 0;
            if (!sen || wact) mstep = 0;
            else if (rstb) begin
                if (mstep == 5) begin
                    fs = ((int'(addr) & MASK) == 32'h0FC0);
                    fr = ((int'(addr) & MASK) == 32'h0C63);
                    mstep = 0;
                end else if ((int'(addr) & MASK) == lead[mstep]) mstep++;
                else mstep = 0;
            end
            done  = (ms == M_ST || ms == M_LD) && rem == 1;
            npend = mpend || !pwr_ok;
            nwip  = 0; ns = ms; nrem = rem - 1;
            case (ms)
                M_IDLE: begin
                    if (!pwr_ok) begin
                        if (mdirty) begin ns = M_ST; nrem = ST; end
                    end else if (mpend) begin ns = M_CLR; nrem = CL; npend = 0; end
                    else if (!mhsbq) begin ns = M_HWIN; nrem = DL; nwip = wnow; end
                    else if (fs) begin ns = M_ST; nrem = ST; end
                    else if (fr) begin ns = M_CLR; nrem = CL; end
                end
                M_HWIN: begin
                    nwip = mwip && wact;
                    if (rem == 1) begin
                        if (mdirty) begin ns = M_ST; nrem = ST; end else ns = M_REL;
                    end
                end
                M_ST:  if (rem == 1) ns = M_REL;
                M_CLR: if (rem == 1) begin ns = M_LD; nrem = XF; end
                M_LD:  if (rem == 1) ns = M_IDLE;
                default: if (mhsbq) ns = M_IDLE;
            endcase
            if (done) mdirty = 0; else if (wnow) mdirty = 1;
            if (done) marm = 0; else if (ce_n || we_n) marm = 1;
            mhsbq = !(ext_pull || ms == M_ST);
            mceq = ce_n; mpend = npend; mwip = nwip; ms = ns; rem = nrem;
        end
    end

    // Compare every output against the reference, away from the active edge.
    always @(negedge clk) begin : cmp
        bit e_busy, e_clr, e_ld, e_rd, e_wr;
        if (started) begin
            e_busy = (ms == M_ST);
            e_clr  = (ms == M_CLR);
            e_ld   = (ms == M_LD);
            e_rd   = pwr_ok && (ms == M_IDLE || ms == M_HWIN);
            e_wr   = pwr_ok && marm && (ms == M_IDLE || (ms == M_HWIN && mwip));
            cyc_checks++;
            if (busy_pull !== e_busy) begin cyc_errors++; $display("FAIL R6 busy_pull act=%b exp=%b t=%0t", busy_pull, e_busy, $time); end
            if (recall_clear !== e_clr) begin cyc_errors++; $display("FAIL R2 recall_clear act=%b exp=%b t=%0t", recall_clear, e_clr, $time); end
            if (recall_load !== e_ld) begin cyc_errors++; $display("FAIL R2 recall_load act=%b exp=%b t=%0t", recall_load, e_ld, $time); end
            if (rd_en !== e_rd) begin cyc_errors++; $display("FAIL R8 rd_en act=%b exp=%b t=%0t", rd_en, e_rd, $time); end
            if (wr_en !== e_wr) begin cyc_errors++; $display("FAIL R9 wr_en act=%b exp=%b t=%0t", wr_en, e_wr, $time); end
            if (busy_pull === 1'b1) n_st++;
            if (recall_clear === 1'b1) n_cl++;
            if (recall_load === 1'b1) n_ld++;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(); @(posedge clk); #1; endtask
    task automatic idle(input int n); repeat (n) tick(); endtask
    task automatic rd(input logic [AW-1:0] a);
        tick(); addr = a; ce_n = 1'b0; we_n = 1'b1;
        tick(); ce_n = 1'b1;
    endtask
    task automatic wr(input logic [AW-1:0] a);
        tick(); addr = a; ce_n = 1'b0; we_n = 1'b0;
        tick(); ce_n = 1'b1; we_n = 1'b1;
    endtask
    task automatic chain(input logic [AW-1:0] last, input logic [AW-1:0] hi);
        for (int i = 0; i < 5; i++) rd(AW'(lead[i]) | hi);
        rd(last | hi);
    endtask

    int b_st, b_cl, b_ld;
    task automatic mark(); b_st = n_st; b_cl = n_cl; b_ld = n_ld; endtask

    // ---------------- directed scenarios ----------------
    initial begin
        idle(3);
        @(negedge clk);
        check("R9 wr_en low in reset", wr_en, 0);
        check("R6 busy_pull low in reset", busy_pull, 0);
        mark();
        tick(); rst_n = 1'b1;
        idle(40);
        check("R7 power-up recall clear cycles", n_cl - b_cl, CL);
        check("R7 power-up recall load cycles", n_ld - b_ld, XF);

        mark(); chain(16'h0FC0, 16'h0); idle(40);
        check("R1 software store length without writes", n_st - b_st, ST);

        mark(); chain(16'h0C63, 16'h0); idle(40);
        check("R2 software recall clear cycles", n_cl - b_cl, CL);
        check("R2 software recall load cycles", n_ld - b_ld, XF);

        mark();
        rd(16'h0E38); rd(16'h31C7); rd(16'h03E0); wr(16'h0100);
        rd(16'h3C1F); rd(16'h303F); rd(16'h0FC0); idle(30);
        check("R3 write aborts chain", n_st - b_st, 0);

        mark();
        rd(16'h0E38); rd(16'h0E38); rd(16'h31C7); rd(16'h03E0);
        rd(16'h3C1F); rd(16'h303F); rd(16'h0FC0); idle(30);
        check("R3 repeated read aborts chain", n_st - b_st, 0);

        mark(); chain(16'h0FC0, 16'hC000); idle(40);
        check("R10 high address bits ignored", n_st - b_st, ST);

        mark();
        tick(); ext_pull = 1'b1;
        idle(3);
        tick(); ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        check("R4 reads continue in window", rd_en, 1);
        check("R4 new write refused in window", wr_en, 0);
        tick(); ce_n = 1'b1; we_n = 1'b1;
        idle(12);
        check("R5 unmodified hardware request skipped", n_st - b_st, 0);
        @(negedge clk);
        check("R6 held off until line high", rd_en, 0);
        tick(); ext_pull = 1'b0; idle(4);
        @(negedge clk);
        check("R6 access back after release", rd_en, 1);

        wr(16'h0123);
        mark(); tick(); ext_pull = 1'b1; idle(40);
        check("R5 modified hardware request stores", n_st - b_st, ST);
        @(negedge clk);
        check("R6 disabled after store while line low", rd_en, 0);
        tick(); ext_pull = 1'b0; idle(4);

        mark();
        tick(); addr = 16'h0042; ce_n = 1'b0; we_n = 1'b0; ext_pull = 1'b1;
        idle(4);
        @(negedge clk);
        check("R4 write in progress keeps wr_en", wr_en, 1);
        tick(); ce_n = 1'b1; we_n = 1'b1;
        idle(40);
        check("R4 in-progress write leads to store", n_st - b_st, ST);
        tick(); ext_pull = 1'b0; idle(4);

        wr(16'h0077);
        mark(); tick(); pwr_ok = 1'b0; idle(2);
        @(negedge clk);
        check("R7 reads off without power", rd_en, 0);
        check("R7 writes off without power", wr_en, 0);
        idle(30);
        check("R7 power-fail store", n_st - b_st, ST);
        tick(); pwr_ok = 1'b1; idle(30);
        check("R7 recall after power return", n_ld - b_ld, XF);

        mark(); tick(); pwr_ok = 1'b0; idle(30);
        check("R5 unmodified power loss skips store", n_st - b_st, 0);
        tick(); pwr_ok = 1'b1; idle(30);
        check("R7 latched recall runs", n_cl - b_cl, CL);

        chain(16'h0C63, 16'h0);
        tick(); ce_n = 1'b0; we_n = 1'b0;
        idle(30);
        @(negedge clk);
        check("R9 held write refused after recall", wr_en, 0);
        tick(); we_n = 1'b1;
        tick(); we_n = 1'b0;
        @(negedge clk);
        check("R9 write re-armed after strobe", wr_en, 1);
        tick(); ce_n = 1'b1; we_n = 1'b1;
        idle(5);

        $display("Simulation finished: %0d checks, %0d errors",
                 checks + cyc_checks, errors + cyc_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        wd_err = 1;
        $display("FAIL watchdog expired act=1 exp=0");
        $display("Simulation finished: %0d checks, %0d errors",
                 checks + cyc_checks + 1, errors + cyc_errors + wd_err);
        $finish;
    end

endmodule